// File: doc/BRIEF.md
# Framebuffer Rectangle Transfer Stepper

This block moves a rectangle of 16-bit pixels between a 32-bit word port and a framebuffer of halfwords. The framebuffer is organised as rows with a pitch of 2^PITCH_LG2 halfwords (1024 by default). Every word holds two pixels. On upload the block unpacks each incoming word into two halfword writes. On download it packs two halfword reads into one returned word. In both directions it walks the rectangle left to right, top to bottom, and stops when the last row is finished.

A transfer begins with a single-cycle start strobe. The strobe carries the direction, the start column and row, and the rectangle width and height. Addresses are computed linearly as row base plus start column plus column offset. They wrap modulo the framebuffer size, 2^(PITCH_LG2+ROWS_LG2) halfwords, so the rectangle may run off the end of a row or off the end of memory. The RAM is modelled inside the block as a synchronous memory with two halfword lanes. ROWS_LG2 must be at least 1.

Top module: `fbrect_stepper`

## Requirements
- R1: After reset, busy_up, busy_dn and rd_valid are all low.
- R2: A start pulse with start_dir=0 raises busy_up on the next cycle; start_dir=1 raises busy_dn instead. A size_w of 0 means a width of 2^PITCH_LG2, and a size_h of 0 means a height of 2^ROWS_LG2. A data word or read request presented in the same cycle as start is ignored.
- R3: Within a 32-bit word, bits [15:0] are the earlier pixel of the walk and bits [31:16] the later one.
- R4: After each pixel the column advances. When it reaches the width, it returns to the start column and the row base advances by one pitch. This can happen between the two halves of one word.
- R5: A transfer ends in the cycle after the word carrying the last pixel of the last row is accepted. If that pixel was the low half of an upload word, the high half is not written.
- R6: Each accepted download request reads two halfwords, even past the rectangle's last pixel. The end of a download is judged only after the second halfword. rd_valid and rd_data appear exactly one cycle after an accepted request.
- R7: Pixel address = (start_y*pitch + start_x + row*pitch + column) modulo the framebuffer size, so writes past the last halfword land at address 0 onward.
- R8: wr_valid while no upload is active writes nothing. rd_req while no download is active produces no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load rectangle and begin a transfer |
| start_dir | input | 1 | 0 = upload (port to RAM), 1 = download |
| start_x | input | PITCH_LG2 | Start column |
| start_y | input | ROWS_LG2 | Start row |
| size_w | input | PITCH_LG2 | Width in pixels, 0 = full pitch |
| size_h | input | ROWS_LG2 | Height in rows, 0 = all rows |
| wr_valid | input | 1 | Upload word present |
| wr_data | input | 32 | Upload word, two pixels |
| rd_req | input | 1 | Download word request |
| rd_valid | output | 1 | Download word valid |
| rd_data | output | 32 | Download word, two pixels |
| busy_up | output | 1 | Upload in progress |
| busy_dn | output | 1 | Download in progress |

## Verification
Two things can fall inside one accepted word: a row wrap and the end of the transfer. A row wrap can also occur between the low and high halves, with the end following on the next half. Odd widths provoke both cases: a three-wide rectangle wraps in the middle of its second word, and one-wide or odd-area rectangles end on a low half. Each case is judged by downloading the region afterwards. The bench compares every returned halfword, including the one beyond the rectangle, against its own address-formula model of the memory, and checks the word count at which busy drops.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;
endpackage

// File: rtl/fbr_step.sv
// One pixel step of the rectangle walk: address of the current pixel and
// the walk position after it.
module fbr_step #(
    parameter int PL = 10,
    parameter int RL = 1,
    parameter int AW = PL + RL
) (
    input  logic [AW-1:0] base_i,
    input  logic [PL-1:0] x0_i,
    input  logic [PL-1:0] col_i,
    input  logic [RL+1:0] rows_i,
    input  logic [PL:0]   w_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] base_o,
    output logic [PL-1:0] col_o,
    output logic [RL+1:0] rows_o
);
    logic wrap;

    always_comb begin
        addr_o = base_i + AW'(x0_i) + AW'(col_i);
        wrap   = (({1'b0, col_i} + (PL+1)'(1)) == w_i);
        col_o  = wrap ? '0 : col_i + PL'(1);
        base_o = wrap ? base_i + (AW'(1) << PL) : base_i;
        rows_o = rows_i + (RL+2)'(wrap);
    end
endmodule

// File: rtl/fbr_ram.sv
// Halfword framebuffer with two lanes sharing one clock; synchronous read.
module fbr_ram #(
    parameter int AW    = 11,
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic [LANES-1:0]       we,
    input  logic                   re,
    input  logic [LANES-1:0][AW-1:0] addr,
    input  logic [LANES-1:0][15:0] wdata,
    output logic [LANES-1:0][15:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [15:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int g = 0; g < LANES; g++) begin
            if (we[g]) mem_q[addr[g]] <= wdata[g];
        end
        if (re) begin
            for (int g = 0; g < LANES; g++) begin
                rdata[g] <= mem_q[addr[g]];
            end
        end
    end
endmodule

// File: rtl/fbrect_stepper.sv
module fbrect_stepper #(
    parameter int PITCH_LG2 = 10,
    parameter int ROWS_LG2  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_dir,
    input  logic [PITCH_LG2-1:0]  start_x,
    input  logic [ROWS_LG2-1:0]   start_y,
    input  logic [PITCH_LG2-1:0]  size_w,
    input  logic [ROWS_LG2-1:0]   size_h,
    input  logic                  wr_valid,
    input  logic [31:0]           wr_data,
    input  logic                  rd_req,
    output logic                  rd_valid,
    output logic [31:0]           rd_data,
    output logic                  busy_up,
    output logic                  busy_dn
);
    import fbr_pkg::*;

    localparam int PL = PITCH_LG2;
    localparam int RL = ROWS_LG2;
    localparam int AW = PL + RL;

    typedef struct packed {
        logic          active;
        dir_e          dir;
        logic [PL-1:0] x0;
        logic [PL:0]   w;
        logic [RL:0]   h;
        logic [AW-1:0] base;
        logic [PL-1:0] col;
        logic [RL+1:0] rows;
        logic          rdv;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0] a0, a1, b1, b2;
    logic [PL-1:0] c1, c2;
    logic [RL+1:0] r1, r2;
    logic          up_go, dn_go, end_lo, end_hi;
    logic [1:0]    ram_we;
    logic [1:0][15:0] ram_rd;

    // Lane 0: low halfword, starts from the registered position.
    fbr_step #(.PL(PL), .RL(RL), .AW(AW)) u_step_lo (
        .base_i(st_q.base), .x0_i(st_q.x0), .col_i(st_q.col), .rows_i(st_q.rows),
        .w_i(st_q.w), .addr_o(a0), .base_o(b1), .col_o(c1), .rows_o(r1)
    );

    // Lane 1: high halfword, continues from lane 0.
    fbr_step #(.PL(PL), .RL(RL), .AW(AW)) u_step_hi (
        .base_i(b1), .x0_i(st_q.x0), .col_i(c1), .rows_i(r1),
        .w_i(st_q.w), .addr_o(a1), .base_o(b2), .col_o(c2), .rows_o(r2)
    );

    fbr_ram #(.AW(AW), .LANES(2)) u_ram (
        .clk(clk), .we(ram_we), .re(dn_go),
        .addr({a1, a0}), .wdata({wr_data[31:16], wr_data[15:0]}),
        .rdata(ram_rd)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdv = 1'b0;
        up_go    = st_q.active && (st_q.dir == DIR_UP) && wr_valid && !start;
        dn_go    = st_q.active && (st_q.dir == DIR_DN) && rd_req && !start;
        end_lo   = (r1 >= {1'b0, st_q.h});
        end_hi   = (r2 >= {1'b0, st_q.h});
        ram_we   = {up_go && !end_lo, up_go};

        if (start) begin
            st_d.active = 1'b1;
            st_d.dir    = dir_e'(start_dir);
            st_d.x0     = start_x;
            st_d.w      = (size_w == '0) ? {1'b1, {PL{1'b0}}} : {1'b0, size_w};
            st_d.h      = (size_h == '0) ? {1'b1, {RL{1'b0}}} : {1'b0, size_h};
            st_d.base   = {start_y, {PL{1'b0}}};
            st_d.col    = '0;
            st_d.rows   = '0;
        end else if (up_go) begin
            if (end_lo || end_hi) begin
                st_d.active = 1'b0;
            end else begin
                st_d.base = b2;
                st_d.col  = c2;
                st_d.rows = r2;
            end
        end else if (dn_go) begin
            st_d.rdv = 1'b1;
            if (end_hi) begin
                st_d.active = 1'b0;
            end else begin
                st_d.base = b2;
                st_d.col  = c2;
                st_d.rows = r2;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_up  = st_q.active && (st_q.dir == DIR_UP);
    assign busy_dn  = st_q.active && (st_q.dir == DIR_DN);
    assign rd_valid = st_q.rdv;
    assign rd_data  = {ram_rd[1], ram_rd[0]};

    AST_START_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy_up || busy_dn)) else $error("start did not activate"); // R2
    AST_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && busy_dn && !start) |=> rd_valid) else $error("read latency"); // R6
    AST_IDLE_NORD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_dn |=> !rd_valid) else $error("read data while idle"); // R8
    AST_IDLE_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_up |-> (ram_we == 2'b00)) else $error("write while idle"); // R8
    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> ({1'b0, st_q.col} < st_q.w)) else $error("column out of range"); // R4
    AST_ROWS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.rows < {1'b0, st_q.h})) else $error("row count past end"); // R5
    AST_HALF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we[1] |-> ram_we[0]) else $error("high half without low half"); // R5
endmodule

// File: tb/test_fbrect_stepper.sv
module test_fbrect_stepper;
    localparam int PL    = 10;
    localparam int RL    = 1;
    localparam int PITCH = 1 << PL;
    localparam int ROWS  = 1 << RL;
    localparam int SIZE  = PITCH * ROWS;

    typedef struct packed {
        int x; int y; int w; int h; int words;
    } case_t;

    // x, y, w, h (0 = max), expected words per transfer
    localparam case_t CASES [7] = '{
        '{0,    0, 0, 0, 1024},
        '{0,    0, 4, 2, 4},
        '{10,   0, 3, 1, 2},
        '{1022, 0, 4, 1, 2},
        '{5,    1, 3, 2, 3},
        '{1023, 1, 3, 1, 2},
        '{7,    1, 1, 1, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, start_dir = 1'b0;
    logic [PL-1:0] start_x = '0, size_w = '0;
    logic [RL-1:0] start_y = '0, size_h = '0;
    logic wr_valid = 1'b0, rd_req = 1'b0;
    logic [31:0] wr_data = '0;
    logic rd_valid, busy_up, busy_dn;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [15:0] model [SIZE];

    always #2.5 clk = ~clk;

    fbrect_stepper #(.PITCH_LG2(PL), .ROWS_LG2(RL)) i_fbrect_stepper (
        .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
        .start_x(start_x), .start_y(start_y), .size_w(size_w), .size_h(size_h),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy_up(busy_up), .busy_dn(busy_dn)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog R5: transfer never finished, cycles=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int eff(input int v, input int full);
        return (v == 0) ? full : v;
    endfunction

    function automatic int addr_of(input int x, input int y, input int w, input int p);
        return ((y + p / w) * PITCH + x + p % w) % SIZE;
    endfunction

    task automatic do_start(input bit dir, input int x, input int y, input int w, input int h,
                            input bit collide);
        start = 1'b1; start_dir = dir;
        start_x = PL'(x); start_y = RL'(y); size_w = PL'(w); size_h = RL'(h);
        wr_valid = collide; wr_data = 32'hDEAD_BEEF; rd_req = collide;
        @(negedge clk);
        start = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
        check(dir ? "R2 busy_dn after start" : "R2 busy_up after start",
              {30'd0, busy_dn, busy_up}, dir ? 32'd2 : 32'd1);
    endtask

    task automatic upload(input int x, input int y, input int wr, input int hr,
                          input int salt, input int exp_words, input bit collide);
        int w = eff(wr, PITCH);
        int h = eff(hr, ROWS);
        int cnt = 0;
        do_start(1'b0, x, y, wr, hr, collide);
        while (busy_up && cnt < 5000) begin
            logic [31:0] d = {16'(cnt * 2 + 1 + salt), 16'(cnt * 2 + salt)};
            wr_valid = 1'b1; wr_data = d;
            model[addr_of(x, y, w, 2 * cnt)] = d[15:0];
            if (2 * cnt + 1 < w * h) model[addr_of(x, y, w, 2 * cnt + 1)] = d[31:16];
            @(negedge clk);
            cnt++;
        end
        wr_valid = 1'b0;
        check("R5 upload words until busy drops", cnt, exp_words);
    endtask

    task automatic download(input int x, input int y, input int wr, input int hr,
                            input int exp_words, input string tag);
        int w = eff(wr, PITCH);
        int cnt = 0;
        do_start(1'b1, x, y, wr, hr, 1'b0);
        while (busy_dn && cnt < 5000) begin
            rd_req = 1'b1;
            @(negedge clk);
            check("R6 rd_valid one cycle after request", {31'd0, rd_valid}, 32'd1);
            check(tag, rd_data, {model[addr_of(x, y, w, 2 * cnt + 1)],
                                 model[addr_of(x, y, w, 2 * cnt)]});
            cnt++;
        end
        rd_req = 1'b0;
        check("R6 download words until busy drops", cnt, exp_words);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {29'd0, rd_valid, busy_dn, busy_up}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: upload then read back each rectangle.
        for (int i = 0; i < 7; i++) begin
            upload(CASES[i].x, CASES[i].y, CASES[i].w, CASES[i].h, i * 32'h1111,
                   CASES[i].words, 1'b0);
            download(CASES[i].x, CASES[i].y, CASES[i].w, CASES[i].h, CASES[i].words,
                     "R3 R4 R7 readback word");
        end

        // Idle port activity must have no effect.
        wr_valid = 1'b1; wr_data = 32'h5A5A_A5A5; rd_req = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R8 no rd_valid while idle", {31'd0, rd_valid}, 32'd0);
        end
        wr_valid = 1'b0; rd_req = 1'b0;
        download(0, 0, 4, 2, 4, "R8 memory untouched by idle writes");
        download(1022, 0, 4, 1, 2, "R8 memory untouched at row edge");

        // Data word in the start cycle is dropped; one more word completes a 2x1 upload.
        upload(20, 0, 2, 1, 32'h7000, 1, 1'b1);
        download(20, 0, 2, 1, 1, "R2 collided word not written");

        // Odd-width upload: high half past the end must stay untouched.
        upload(100, 1, 1, 1, 32'h3300, 1, 1'b0);
        download(100, 0, 1, 2, 1, "R5 discarded high half");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule